// File: doc/BRIEF.md
# Slave poll responder

This block is the bus-side answering logic of a slave station on a shared broadcast frame bus. Every frame on the bus reaches every station, and that includes the frames a station sends itself. Each frame carries a kind bit (poll or response), a source station number and a destination station number. The block looks at each received frame. It acts only on a poll whose destination is its own station number and which another station sent. For such a poll it builds a reply: a response frame addressed back to the sender and carrying its own number as the source.

The reply waits in a single-entry transmit slot, which is drained through a valid/ready handshake. If a second qualifying poll arrives while the slot is still waiting for ready, the second poll is discarded and a sticky overrun indicator is raised. A station number of zero means the station has not been configured, and the block then never answers.

Top module: `poll_responder`

## Requirements
- R1: While reset is low and in the first cycle after it, tx_valid and overrun are both 0.
- R2: A received frame with rx_valid=1, rx_kind=0 (poll), rx_dst equal to node_id, rx_src different from node_id and node_id nonzero is a qualifying poll. When the slot is empty, tx_valid is 1 in the cycle after the clock edge that samples it.
- R3: The reply has tx_kind=1 (response), tx_src equal to node_id and tx_dst equal to the rx_src of the poll.
- R4: A frame with rx_kind=1 (response) never produces a reply.
- R5: A poll whose rx_dst differs from node_id never produces a reply.
- R6: A poll whose rx_src equals node_id (the station's own frame seen on the bus) never produces a reply.
- R7: While node_id is 0, tx_valid stays 0 whatever frames arrive.
- R8: While tx_valid is 1 and tx_ready is 0, tx_valid, tx_kind, tx_src and tx_dst stay unchanged into the next cycle. After an edge that samples tx_valid=1 and tx_ready=1 with no new qualifying poll, tx_valid is 0.
- R9: A qualifying poll sampled while tx_valid=1 and tx_ready=0 is dropped: the pending reply keeps its fields, and overrun becomes 1 in the next cycle.
- R10: A qualifying poll sampled in the same cycle in which the pending reply is accepted (tx_valid=1, tx_ready=1) is loaded at once: tx_valid stays 1 and the fields become those of the new reply.
- R11: Once overrun is 1 it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| node_id | input | NODE_W | Own station number, static; 0 means unconfigured |
| rx_valid | input | 1 | A frame is present on the receive side this cycle |
| rx_kind | input | 1 | Frame kind: 0 poll, 1 response |
| rx_src | input | NODE_W | Source station number of the received frame |
| rx_dst | input | NODE_W | Destination station number of the received frame |
| tx_valid | output | 1 | Reply frame is offered |
| tx_ready | input | 1 | Transmit side takes the reply on this edge |
| tx_kind | output | 1 | Reply kind, always 1 (response) |
| tx_src | output | NODE_W | Reply source, the own station number |
| tx_dst | output | NODE_W | Reply destination, the poller's number |
| overrun | output | 1 | Sticky: a qualifying poll was dropped |

## Verification
The properties take node_id as constant between resets. The check that node_id 0 keeps the block silent therefore assumes that no reply was pending when the number became 0. The bench changes node_id only while reset is asserted, and it starts a new reset each time the station number has to change. The receive fields count only when rx_valid is 1. The bench also drives random-looking field values during idle cycles, and these must leave the block unaffected.

// File: rtl/pr_pkg.sv
package pr_pkg;

   typedef enum logic {
      PR_POLL = 1'b0,
      PR_RESP = 1'b1
   } pr_kind_e;

   localparam int PR_MIN_NODE_W = 2;
   localparam int PR_MAX_NODE_W = 16;

endpackage

// File: rtl/pr_match.sv
module pr_match
   import pr_pkg::*;
#(
   parameter int NODE_W = 8
) (
   input  logic [NODE_W-1:0] node_id,
   input  logic              rx_valid,
   input  logic              rx_kind,
   input  logic [NODE_W-1:0] rx_src,
   input  logic [NODE_W-1:0] rx_dst,
   output logic              hit
);

   logic configured;
   logic for_me;
   logic from_other;
   logic is_poll;

   always_comb begin
      configured = (node_id != '0);
      for_me     = (rx_dst == node_id);
      from_other = (rx_src != node_id);
      is_poll    = (rx_kind == PR_POLL);
      hit        = rx_valid && is_poll && for_me && from_other && configured;
   end

endmodule

// File: rtl/pr_txslot.sv
module pr_txslot
   import pr_pkg::*;
#(
   parameter int NODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic [NODE_W-1:0] own_id,
   input  logic [NODE_W-1:0] poller_id,
   input  logic              tx_ready,
   output logic              tx_valid,
   output logic              tx_kind,
   output logic [NODE_W-1:0] tx_src,
   output logic [NODE_W-1:0] tx_dst,
   output logic              overrun
);

   logic slot_free;
   logic load;
   logic drop;

   always_comb begin
      slot_free = !tx_valid || tx_ready;
      load      = hit && slot_free;
      drop      = hit && !slot_free;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_valid <= 1'b0;
         tx_kind  <= PR_RESP;
         tx_src   <= '0;
         tx_dst   <= '0;
      end else if (load) begin
         tx_valid <= 1'b1;
         tx_kind  <= PR_RESP;
         tx_src   <= own_id;
         tx_dst   <= poller_id;
      end else if (tx_ready) begin
         tx_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         overrun <= 1'b0;
      end else if (drop) begin
         overrun <= 1'b1;
      end
   end

endmodule

// File: rtl/poll_responder.sv
module poll_responder
   import pr_pkg::*;
#(
   parameter int NODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NODE_W-1:0] node_id,
   input  logic              rx_valid,
   input  logic              rx_kind,
   input  logic [NODE_W-1:0] rx_src,
   input  logic [NODE_W-1:0] rx_dst,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic              tx_kind,
   output logic [NODE_W-1:0] tx_src,
   output logic [NODE_W-1:0] tx_dst,
   output logic              overrun
);

   generate
      if (NODE_W < PR_MIN_NODE_W || NODE_W > PR_MAX_NODE_W) begin : g_bad_width
         $error("poll_responder: NODE_W out of supported range");
      end
   endgenerate

   logic hit;

   pr_match #(.NODE_W(NODE_W)) i_match (
      .node_id  (node_id),
      .rx_valid (rx_valid),
      .rx_kind  (rx_kind),
      .rx_src   (rx_src),
      .rx_dst   (rx_dst),
      .hit      (hit)
   );

   pr_txslot #(.NODE_W(NODE_W)) i_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (hit),
      .own_id    (node_id),
      .poller_id (rx_src),
      .tx_ready  (tx_ready),
      .tx_valid  (tx_valid),
      .tx_kind   (tx_kind),
      .tx_src    (tx_src),
      .tx_dst    (tx_dst),
      .overrun   (overrun)
   );

endmodule

// File: rtl/pr_checker.sv
module pr_checker
   import pr_pkg::*;
#(
   parameter int NODE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NODE_W-1:0] node_id,
   input logic              rx_valid,
   input logic              rx_kind,
   input logic [NODE_W-1:0] rx_src,
   input logic [NODE_W-1:0] rx_dst,
   input logic              tx_valid,
   input logic              tx_ready,
   input logic              tx_kind,
   input logic [NODE_W-1:0] tx_src,
   input logic [NODE_W-1:0] tx_dst,
   input logic              overrun
);

   logic past_rst_n;
   always_ff @(posedge clk) past_rst_n <= rst_n;

   // R1
   always @(negedge clk) begin
      if (!past_rst_n && !rst_n) begin
         reset_quiet_chk: assert (!tx_valid && !overrun)
            else $error("outputs active during reset");
      end
   end

   // R2 R3
   reply_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_kind == PR_POLL && rx_dst == node_id && rx_src != node_id
       && node_id != '0 && !tx_valid)
      |=> (tx_valid && tx_kind == PR_RESP && tx_src == node_id && tx_dst == $past(rx_src)));

   // R4
   resp_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_valid && (!rx_valid || rx_kind == PR_RESP)) |=> !tx_valid);

   // R6
   own_src_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_valid && rx_valid && rx_src == node_id) |=> !tx_valid);

   // R7
   unconfigured_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_valid && node_id == '0) |=> !tx_valid);

   // R8
   hold_until_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready)
      |=> (tx_valid && $stable(tx_kind) && $stable(tx_src) && $stable(tx_dst)));

   // R9
   overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(tx_valid && !tx_ready && rx_valid));

   // R11
   overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

endmodule

bind poll_responder pr_checker #(.NODE_W(NODE_W)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .node_id  (node_id),
   .rx_valid (rx_valid),
   .rx_kind  (rx_kind),
   .rx_src   (rx_src),
   .rx_dst   (rx_dst),
   .tx_valid (tx_valid),
   .tx_ready (tx_ready),
   .tx_kind  (tx_kind),
   .tx_src   (tx_src),
   .tx_dst   (tx_dst),
   .overrun  (overrun)
);

// File: tb/test_poll_responder.sv
`timescale 1ns/1ps
module test_poll_responder;

   localparam int NW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NW-1:0] node_id = 8'd5;
   logic          rx_valid = 1'b0;
   logic          rx_kind = 1'b0;
   logic [NW-1:0] rx_src = '0;
   logic [NW-1:0] rx_dst = '0;
   logic          tx_ready = 1'b0;
   logic          tx_valid;
   logic          tx_kind;
   logic [NW-1:0] tx_src;
   logic [NW-1:0] tx_dst;
   logic          overrun;

   always #4 clk = ~clk;

   poll_responder #(.NODE_W(NW)) i_poll_responder (
      .clk(clk), .rst_n(rst_n), .node_id(node_id),
      .rx_valid(rx_valid), .rx_kind(rx_kind), .rx_src(rx_src), .rx_dst(rx_dst),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_kind(tx_kind),
      .tx_src(tx_src), .tx_dst(tx_dst), .overrun(overrun)
   );

   int vectors = 0;
   int errors  = 0;
   bit done    = 0;

   // behavioural reference
   bit m_valid = 0;
   int m_src = 0;
   int m_dst = 0;
   bit m_ovr = 0;

   task automatic model_step();
      bit hit;
      hit = rx_valid && rx_kind == 1'b0 && int'(rx_dst) == int'(node_id)
            && int'(rx_src) != int'(node_id) && node_id != 0;
      if (!rst_n) begin
         m_valid = 0; m_ovr = 0;
      end else begin
         if (hit && m_valid && !tx_ready) m_ovr = 1;
         if (hit && (!m_valid || tx_ready)) begin
            m_valid = 1; m_src = int'(node_id); m_dst = int'(rx_src);
         end else if (tx_ready) begin
            m_valid = 0;
         end
      end
   endtask

   task automatic compare(input string tag);
      vectors++;
      if (tx_valid !== m_valid) begin
         errors++;
         $display("FAIL %s tx_valid actual %0b expected %0b", tag, tx_valid, m_valid);
      end else if (m_valid && (tx_kind !== 1'b1 || int'(tx_src) != m_src || int'(tx_dst) != m_dst)) begin
         errors++;
         $display("FAIL %s reply actual kind=%0b src=%0d dst=%0d expected kind=1 src=%0d dst=%0d",
                  tag, tx_kind, tx_src, tx_dst, m_src, m_dst);
      end
      if (overrun !== m_ovr) begin
         errors++;
         $display("FAIL %s overrun actual %0b expected %0b", tag, overrun, m_ovr);
      end
   endtask

   task automatic cyc(input bit v, input bit k, input int s, input int d,
                      input bit rdy, input string tag);
      rx_valid = v; rx_kind = k; rx_src = NW'(s); rx_dst = NW'(d); tx_ready = rdy;
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare(tag);
   endtask

   task automatic idle(input int n, input bit rdy, input string tag);
      for (int i = 0; i < n; i++) cyc(1'b0, i[0], 17 * i, 5, rdy, tag);
   endtask

   task automatic do_reset(input int id);
      rst_n = 1'b0; node_id = NW'(id);
      cyc(1'b0, 1'b0, 0, 0, 1'b0, "R1 reset");
      cyc(1'b1, 1'b0, 1, id, 1'b0, "R1 reset");
      rst_n = 1'b1;
      cyc(1'b0, 1'b0, 0, 0, 1'b0, "R1 after reset");
   endtask

   initial begin
      do_reset(5);
      idle(2, 1'b0, "R1 idle");
      // R2 R3: poll from 1, held while not ready
      cyc(1'b1, 1'b0, 1, 5, 1'b0, "R2 poll");
      idle(3, 1'b0, "R3 R8 hold");
      cyc(1'b0, 1'b0, 0, 0, 1'b1, "R8 accept");
      idle(1, 1'b0, "R8 after accept");
      // R4 response kind ignored
      cyc(1'b1, 1'b1, 1, 5, 1'b0, "R4 response frame");
      idle(1, 1'b0, "R4 check");
      // R5 other destination
      cyc(1'b1, 1'b0, 1, 6, 1'b0, "R5 foreign dst");
      cyc(1'b1, 1'b0, 2, 0, 1'b0, "R5 dst zero");
      idle(1, 1'b0, "R5 check");
      // R6 own frame on bus
      cyc(1'b1, 1'b0, 5, 5, 1'b0, "R6 own source");
      idle(1, 1'b0, "R6 check");
      // R9 overrun
      cyc(1'b1, 1'b0, 1, 5, 1'b0, "R9 first poll");
      cyc(1'b1, 1'b0, 3, 5, 1'b0, "R9 dropped poll");
      idle(2, 1'b0, "R9 fields kept");
      // R10 replace in accept cycle
      cyc(1'b1, 1'b0, 7, 5, 1'b1, "R10 replace");
      cyc(1'b0, 1'b0, 0, 0, 1'b0, "R10 new fields");
      cyc(1'b0, 1'b0, 0, 0, 1'b1, "R8 drain");
      // R11 sticky
      idle(4, 1'b1, "R11 sticky overrun");
      cyc(1'b1, 1'b0, 9, 5, 1'b1, "R2 ready high poll");
      idle(2, 1'b1, "R8 ready high drain");
      // R7 unconfigured station
      do_reset(0);
      cyc(1'b1, 1'b0, 1, 0, 1'b0, "R7 poll to zero");
      cyc(1'b1, 1'b0, 1, 5, 1'b0, "R7 poll to five");
      idle(2, 1'b0, "R7 silent");
      // new station number after reset
      do_reset(200);
      cyc(1'b1, 1'b0, 1, 200, 1'b0, "R3 other node number");
      idle(1, 1'b1, "R3 check");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

endmodule